// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Controller

This block lights a four-digit seven-segment display whose digits share their segment lines, so only part of the display can be lit at any instant. Software-side logic loads one 8-bit pattern per digit through a plain write port. Bit 0 through bit 6 are segments a through g and bit 7 is the decimal point, and a set bit means "lit". A prescaler divides the system clock into a one-cycle scan tick. Each tick moves the controller to its next scan phase, and the controller drives the matching digit enables and segment lines.

Two scan methods are available through `scan_mode`. In digit scan (`scan_mode` = 0) there are four phases and phase p lights digit p with its own pattern. In segment scan (`scan_mode` = 1) there are eight phases and phase p drives only segment line p. In that phase every digit whose pattern has bit p set is enabled. To refresh the whole display at 50 Hz from 100 MHz, digit scan needs a tick every 500,000 clocks and segment scan needs one every 250,000 clocks. A parameter can replace the exact divider with a free-running power-of-two counter. That counter wraps every 2^19 clocks in digit scan and every 2^18 in segment scan, which is close to 47.7 Hz and needs a much cheaper terminal test.

The sequencer is a three-state machine:
- BLANK is entered at reset and shows nothing.
- GAP lasts one cycle. Every output is blanked at each phase change so that no digit shows a stale pattern.
- SHOW drives the phase.

The transitions are:
- BLANK→GAP on the first tick. Scanning starts at phase 0 in the mode present at that moment.
- GAP→SHOW after exactly one cycle.
- SHOW→GAP on every later tick, which moves to the next phase.
- SHOW→SHOW while no tick arrives.

Top module: `seg_scan_ctrl`

## Requirements
- R1: While `rst` is high, and after it until the first scan tick, every digit enable and every segment line sits at its inactive level. With the default active-low polarity that is `digit_en` = 4'b1111 and `seg_line` = 8'hFF.
- R2: With the exact divider, `scan_tick` is one cycle wide. It repeats every `DIV_DIGIT` clocks while `scan_mode` is 0 and every `DIV_SEG` clocks while `scan_mode` is 1.
- R3: With the power-of-two divider, `scan_tick` repeats every 2^`POW2_BITS` clocks while `scan_mode` is 0 and every 2^(`POW2_BITS`-1) clocks while `scan_mode` is 1.
- R4: In the cycle that follows every scan tick, all digit enables and all segment lines are inactive.
- R5: In digit scan, phases run 0,1,2,3,0,… and the phase advances by one per tick. During phase p only digit p is enabled (`digit_en` bit p low), and `seg_line` is the inverse of digit p's pattern.
- R6: In segment scan, phases run 0 through 7 and wrap. During phase p only segment line p is active (`seg_line` bit p low), and `digit_en` bit d is low exactly when bit p of digit d's pattern is 1.
- R7: When `scan_mode` differs, at a tick, from the mode in use, the next shown phase is phase 0 of the new mode.
- R8: A write changes nothing on the display until the next scan tick. The pattern shown in the current phase stays as it was.
- R9: A write with `wr_en` high stores `wr_data` as the pattern of the digit numbered by `wr_addr`. The patterns of the other digits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_mode | input | 1 | 0 selects digit scan, 1 selects segment scan |
| wr_en | input | 1 | Write strobe for a digit pattern |
| wr_addr | input | 2 | Digit number for the write |
| wr_data | input | 8 | Pattern: bit 0..6 = segments a..g, bit 7 = decimal point, 1 = lit |
| digit_en | output | 4 | Digit enables, active low by default |
| seg_line | output | 8 | Segment lines in pattern bit order, active low by default |
| scan_tick | output | 1 | One-cycle pulse at each phase change |

## Verification
The hardest situation to reach is a mode switch that lands in the middle of a phase and then has to restart the scan at phase 0 in the other mode. A write landing mid-phase is just as hard, because it must stay invisible until the boundary. The bench shortens both divider periods to a few clocks. It synchronises its driver to the observed `scan_tick` and acts a fixed number of cycles after it, so mode flips and writes always fall strictly inside a phase. Every cycle of the display is then compared with a predicted sequence of blank and pattern items. Tick spacing is also checked on a second instance that uses the power-of-two divider.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_GAP   = 2'd1,
        ST_SHOW  = 2'd2
    } scan_state_e;

    // Scan method
    typedef enum logic {
        SCAN_DIGIT   = 1'b0,
        SCAN_SEGMENT = 1'b1
    } scan_mode_e;

endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler
    import seg_scan_pkg::*;
#(
    parameter int unsigned DIV_DIGIT = 500000,
    parameter int unsigned DIV_SEG   = 250000,
    parameter bit          POW2      = 1'b0,
    parameter int unsigned POW2_BITS = 19
) (
    input  logic       clk,
    input  logic       rst,
    input  scan_mode_e mode,
    output logic       tick
);

    if (DIV_DIGIT < 2 || DIV_SEG < 2 || POW2_BITS < 2) begin : g_bad_cfg
        $error("scan_prescaler: periods must be at least two clocks");
    end

    if (!POW2) begin : g_exact
        localparam int unsigned TOP = (DIV_DIGIT > DIV_SEG) ? DIV_DIGIT : DIV_SEG;
        localparam int unsigned CW  = $clog2(TOP);
        localparam logic [CW-1:0] LAST_D = CW'(DIV_DIGIT - 1);
        localparam logic [CW-1:0] LAST_S = CW'(DIV_SEG - 1);

        logic [CW-1:0] cnt;
        logic [CW-1:0] last;
        logic          at_end;

        // ">=" keeps the counter in range when the mode shortens the period
        always_comb begin
            last   = (mode == SCAN_SEGMENT) ? LAST_S : LAST_D;
            at_end = (cnt >= last);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt  <= '0;
                tick <= 1'b0;
            end else begin
                cnt  <= at_end ? '0 : cnt + 1'b1;
                tick <= at_end;
            end
        end
    end else begin : g_pow2
        logic [POW2_BITS-1:0] cnt;
        logic                 at_end;

        // Segment scan halves the period by ignoring the top bit
        always_comb begin
            if (mode == SCAN_SEGMENT) at_end = &cnt[POW2_BITS-2:0];
            else                      at_end = &cnt;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt  <= '0;
                tick <= 1'b0;
            end else begin
                cnt  <= cnt + 1'b1;
                tick <= at_end;
            end
        end
    end

endmodule

// File: rtl/code_bank.sv
module code_bank #(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned SEG_W      = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [$clog2(NUM_DIGITS)-1:0]         wr_addr,
    input  logic [SEG_W-1:0]                      wr_data,
    input  logic                                  load,
    output logic [NUM_DIGITS-1:0][SEG_W-1:0]      active
);

    localparam int unsigned AW = $clog2(NUM_DIGITS);

    logic [NUM_DIGITS-1:0][SEG_W-1:0] pending;

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        // Write side: holds the newest pattern for this digit
        always_ff @(posedge clk) begin
            if (rst)                                  pending[d] <= '0;
            else if (wr_en && wr_addr == AW'(d))      pending[d] <= wr_data;
        end

        // Display side: copied only at a phase boundary
        always_ff @(posedge clk) begin
            if (rst)       active[d] <= '0;
            else if (load) active[d] <= pending[d];
        end
    end

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import seg_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 4,
    parameter int unsigned SEG_W      = 8,
    parameter int unsigned PH_W       = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  scan_mode_e                       mode_in,
    input  logic [NUM_DIGITS-1:0][SEG_W-1:0] codes,
    output scan_state_e                      state,
    output logic [PH_W-1:0]                  phase,
    output scan_mode_e                       mode_q,
    output logic [NUM_DIGITS-1:0]            en_act,
    output logic [SEG_W-1:0]                 seg_act
);

    localparam logic [PH_W-1:0] LAST_DIG = PH_W'(NUM_DIGITS - 1);
    localparam logic [PH_W-1:0] LAST_SEG = PH_W'(SEG_W - 1);

    scan_state_e     state_d;
    logic [PH_W-1:0] phase_d;
    scan_mode_e      mode_d;
    logic [PH_W-1:0] last_ph;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_BLANK;
            phase  <= '0;
            mode_q <= SCAN_DIGIT;
        end else begin
            state  <= state_d;
            phase  <= phase_d;
            mode_q <= mode_d;
        end
    end

    // Next state
    always_comb begin
        last_ph = (mode_q == SCAN_SEGMENT) ? LAST_SEG : LAST_DIG;
        state_d = state;
        phase_d = phase;
        mode_d  = mode_q;
        unique case (state)
            ST_BLANK: begin
                if (tick) begin
                    state_d = ST_GAP;
                    phase_d = '0;
                    mode_d  = mode_in;
                end
            end
            ST_GAP: begin
                state_d = ST_SHOW;
            end
            ST_SHOW: begin
                if (tick) begin
                    state_d = ST_GAP;
                    if (mode_in != mode_q) begin
                        phase_d = '0;
                        mode_d  = mode_in;
                    end else if (phase == last_ph) begin
                        phase_d = '0;
                    end else begin
                        phase_d = phase + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_BLANK;
            end
        endcase
    end

    // Outputs (logical "on" levels)
    always_comb begin
        en_act  = '0;
        seg_act = '0;
        if (state == ST_SHOW) begin
            if (mode_q == SCAN_DIGIT) begin
                for (int d = 0; d < NUM_DIGITS; d++) begin
                    if (phase == PH_W'(d)) begin
                        en_act[d] = 1'b1;
                        seg_act   = codes[d];
                    end
                end
            end else begin
                for (int s = 0; s < SEG_W; s++) begin
                    if (phase == PH_W'(s)) begin
                        seg_act[s] = 1'b1;
                        for (int d = 0; d < NUM_DIGITS; d++) begin
                            en_act[d] = codes[d][s];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
    import seg_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS     = 4,
    parameter int unsigned SEG_W          = 8,
    parameter int unsigned DIV_DIGIT      = 500000,
    parameter int unsigned DIV_SEG        = 250000,
    parameter bit          POW2           = 1'b0,
    parameter int unsigned POW2_BITS      = 19,
    parameter bit          DIG_ACTIVE_LOW = 1'b1,
    parameter bit          SEG_ACTIVE_LOW = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scan_mode,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_DIGITS)-1:0] wr_addr,
    input  logic [SEG_W-1:0]              wr_data,
    output logic [NUM_DIGITS-1:0]         digit_en,
    output logic [SEG_W-1:0]              seg_line,
    output logic                          scan_tick
);

    localparam int unsigned PHASES = (NUM_DIGITS > SEG_W) ? NUM_DIGITS : SEG_W;
    localparam int unsigned PH_W   = $clog2(PHASES);

    scan_mode_e                       mode_sel;
    scan_state_e                      fsm_state;
    logic [PH_W-1:0]                  fsm_phase;
    scan_mode_e                       fsm_mode;
    logic [NUM_DIGITS-1:0][SEG_W-1:0] act_codes;
    logic [NUM_DIGITS-1:0]            en_act;
    logic [SEG_W-1:0]                 seg_act;

    assign mode_sel = scan_mode_e'(scan_mode);

    scan_prescaler #(
        .DIV_DIGIT (DIV_DIGIT),
        .DIV_SEG   (DIV_SEG),
        .POW2      (POW2),
        .POW2_BITS (POW2_BITS)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_sel),
        .tick (scan_tick)
    );

    code_bank #(
        .NUM_DIGITS (NUM_DIGITS),
        .SEG_W      (SEG_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (scan_tick),
        .active  (act_codes)
    );

    scan_fsm #(
        .NUM_DIGITS (NUM_DIGITS),
        .SEG_W      (SEG_W),
        .PH_W       (PH_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (scan_tick),
        .mode_in (mode_sel),
        .codes   (act_codes),
        .state   (fsm_state),
        .phase   (fsm_phase),
        .mode_q  (fsm_mode),
        .en_act  (en_act),
        .seg_act (seg_act)
    );

    if (DIG_ACTIVE_LOW) begin : g_dig_low
        assign digit_en = ~en_act;
    end else begin : g_dig_high
        assign digit_en = en_act;
    end

    if (SEG_ACTIVE_LOW) begin : g_seg_low
        assign seg_line = ~seg_act;
    end else begin : g_seg_high
        assign seg_line = seg_act;
    end

endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk
    import seg_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS     = 4,
    parameter int unsigned SEG_W          = 8,
    parameter int unsigned PH_W           = 3,
    parameter bit          DIG_ACTIVE_LOW = 1'b1,
    parameter bit          SEG_ACTIVE_LOW = 1'b1
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             scan_tick,
    input scan_state_e                      state,
    input logic [PH_W-1:0]                  phase,
    input scan_mode_e                       mode_q,
    input logic [NUM_DIGITS-1:0]            digit_en,
    input logic [SEG_W-1:0]                 seg_line,
    input logic [NUM_DIGITS-1:0][SEG_W-1:0] codes
);

    logic [NUM_DIGITS-1:0] en_on;
    logic [SEG_W-1:0]      seg_on;

    assign en_on  = DIG_ACTIVE_LOW ? ~digit_en : digit_en;
    assign seg_on = SEG_ACTIVE_LOW ? ~seg_line : seg_line;

    // R1: reset leaves the display dark
    a_r1_reset_blank: assert property (@(posedge clk)
        rst |=> (en_on == '0 && seg_on == '0));

    // R2: the scan tick never lasts two cycles
    a_r2_tick_pulse: assert property (@(posedge clk) disable iff (rst)
        scan_tick |=> !scan_tick);

    // R4: the cycle after a tick is dark
    a_r4_dead_cycle: assert property (@(posedge clk) disable iff (rst)
        scan_tick |=> (en_on == '0 && seg_on == '0));

    // R4: nothing lit while the sequencer is in its gap state
    a_r4_gap_dark: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> (en_on == '0 && seg_on == '0));

    // R5: digit scan lights at most one digit, on a phase in range
    a_r5_one_digit: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SCAN_DIGIT) |-> ($onehot0(en_on) && phase < PH_W'(NUM_DIGITS)));

    // R6: segment scan drives at most one segment line
    a_r6_one_line: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SCAN_SEGMENT) |-> $onehot0(seg_on));

    // R8: displayed patterns change only at a tick
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !scan_tick |=> $stable(codes));

endmodule

bind seg_scan_ctrl seg_scan_chk #(
    .NUM_DIGITS     (NUM_DIGITS),
    .SEG_W          (SEG_W),
    .PH_W           (PH_W),
    .DIG_ACTIVE_LOW (DIG_ACTIVE_LOW),
    .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_tick (scan_tick),
    .state     (fsm_state),
    .phase     (fsm_phase),
    .mode_q    (fsm_mode),
    .digit_en  (digit_en),
    .seg_line  (seg_line),
    .codes     (act_codes)
);

// File: tb/seg_scan_ctrl_tb.sv
module seg_scan_ctrl_tb;

    localparam int DD = 8;   // digit-scan period, exact divider
    localparam int DS = 6;   // segment-scan period, exact divider
    localparam int PB = 4;   // power-of-two divider width

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] digit_en;
    logic [7:0] seg_line;
    logic       scan_tick;
    logic [3:0] p2_en;
    logic [7:0] p2_seg;
    logic       p2_tick;

    always #5 clk = ~clk;

    seg_scan_ctrl #(.DIV_DIGIT(DD), .DIV_SEG(DS)) u_dut (
        .clk(clk), .rst(rst), .scan_mode(scan_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .digit_en(digit_en),
        .seg_line(seg_line), .scan_tick(scan_tick));

    seg_scan_ctrl #(.POW2(1'b1), .POW2_BITS(PB)) u_p2 (
        .clk(clk), .rst(rst), .scan_mode(scan_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .digit_en(p2_en),
        .seg_line(p2_seg), .scan_tick(p2_tick));

    typedef struct {
        logic [3:0] en;
        logic [7:0] seg;
        int         req;
    } disp_item_t;

    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    disp_item_t exp_q[$];
    disp_item_t cur;
    logic [7:0] sh_m[4];
    logic [7:0] act_m[4];
    int         ph_m = 0;
    bit         mode_m = 1'b0;
    bit         started = 1'b0;
    int         pat_tag = 0;
    int         since = 0, since2 = 0;
    bit         have_prev = 1'b0, have_prev2 = 1'b0;
    bit         skip = 1'b0, skip2 = 1'b0;
    event       ev_tick;

    function automatic disp_item_t blank_item(int req);
        disp_item_t it;
        it.en = 4'hF; it.seg = 8'hFF; it.req = req;
        return it;
    endfunction

    // R5 / R6 expected display for a phase
    function automatic disp_item_t show_item(int ph, bit m, int req);
        disp_item_t it;
        logic [3:0] e = '0;
        logic [7:0] s = '0;
        if (!m) begin
            e[ph] = 1'b1;
            s     = act_m[ph];
        end else begin
            s[ph] = 1'b1;
            for (int d = 0; d < 4; d++) e[d] = act_m[d][ph];
        end
        it.en = ~e; it.seg = ~s; it.req = req;
        return it;
    endfunction

    task automatic check_int(int req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver-side prediction at each observed tick: pushes the gap and the next phase
    task automatic predict();
        int req;
        bit changed;
        changed = started && (scan_mode != mode_m);
        if (!started || changed) begin
            ph_m   = 0;
            mode_m = scan_mode;
            started = 1'b1;
        end else begin
            ph_m = (ph_m == (mode_m ? 7 : 3)) ? 0 : ph_m + 1;
        end
        for (int d = 0; d < 4; d++) act_m[d] = sh_m[d];
        if (changed)           req = 7;   // R7 restart at phase 0
        else if (pat_tag != 0) req = pat_tag;
        else                   req = mode_m ? 6 : 5;
        exp_q.push_back(blank_item(4));   // R4 dead cycle
        exp_q.push_back(show_item(ph_m, mode_m, req));
    endtask

    // Monitor: compares the display every cycle, away from the active edge
    initial cur = blank_item(1);   // R1 dark until the first tick
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            n_vec++;
            if (digit_en !== cur.en || seg_line !== cur.seg) begin
                n_bad++;
                $display("FAIL R%0d display at %0t: actual en=%b seg=%b expected en=%b seg=%b",
                         cur.req, $time, digit_en, seg_line, cur.en, cur.seg);
            end
            since++;
            if (scan_tick) begin
                // R2 exact tick spacing
                if (have_prev && !skip)
                    check_int(2, "tick spacing", since, scan_mode ? DS : DD);
                have_prev = 1'b1; skip = 1'b0; since = 0;
                predict();
                ->ev_tick;
            end
            since2++;
            if (p2_tick) begin
                // R3 power-of-two tick spacing
                if (have_prev2 && !skip2)
                    check_int(3, "pow2 tick spacing", since2, scan_mode ? (1 << (PB-1)) : (1 << PB));
                have_prev2 = 1'b1; skip2 = 1'b0; since2 = 0;
            end
        end
    end

    // R9: write one pattern
    task automatic wr(logic [1:0] a, logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        sh_m[a] = v;
    endtask

    task automatic set_mode(bit m);
        scan_mode = m;
        skip  = 1'b1;
        skip2 = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // R8: a mid-phase write leaves the display as it was
    task automatic write_mid_phase(logic [1:0] a, logic [7:0] v);
        logic [3:0] e0;
        logic [7:0] s0;
        @(ev_tick);
        repeat (2) @(posedge clk);
        #1;
        e0 = digit_en; s0 = seg_line;
        wr(a, v);
        @(negedge clk);
        check_int(8, "digit_en held after write", int'(digit_en), int'(e0));
        check_int(8, "seg_line held after write", int'(seg_line), int'(s0));
    endtask

    initial begin
        for (int d = 0; d < 4; d++) begin
            sh_m[d]  = '0;
            act_m[d] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state checked while reset is held
        check_int(1, "digit_en in reset", int'(digit_en), 4'hF);
        check_int(1, "seg_line in reset", int'(seg_line), 8'hFF);
        rst = 1'b0;
        // R9 load the four patterns before the first tick
        wr(2'd0, 8'h3F);
        wr(2'd1, 8'h06);
        wr(2'd2, 8'h5B);
        wr(2'd3, 8'hCF);
        // R5 digit scan, several rotations
        repeat (10) @(ev_tick);
        // R8 / R9 mid-phase write to digit 2
        pat_tag = 9;
        write_mid_phase(2'd2, 8'h79);
        repeat (6) @(ev_tick);
        pat_tag = 0;
        // R7 switch to segment scan mid-phase
        @(ev_tick);
        repeat (3) @(posedge clk);
        #1;
        set_mode(1'b1);
        // R6 segment scan over more than two full sweeps
        repeat (18) @(ev_tick);
        write_mid_phase(2'd0, 8'hA5);
        repeat (10) @(ev_tick);
        // R7 back to digit scan
        @(ev_tick);
        repeat (2) @(posedge clk);
        #1;
        set_mode(1'b0);
        repeat (10) @(ev_tick);
        repeat (3) @(negedge clk);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual no completion expected completion");
            finish_run();
        end
    end

endmodule